// File: doc/BRIEF.md
# Sampling Converter Sequencer with Power States

This block sits beside a 14-bit successive-approximation converter and runs its digital handshake for the host. Asking for a sample is a single-cycle `req_i` pulse. The sequencer pulls the start line low, waits for the converter's end-of-conversion line to rise, and captures the parallel word at that moment. It then returns the word as a 16-bit value: sign-extended when the bipolar range is selected, zero-extended when the unipolar range is selected.

Between samples the converter can be kept in one of three power states, chosen by `mode_i`:

- **Full power.** The converter stays awake.
- **Auto-nap.** The start and shutdown lines move together. The converter drops into nap after every conversion, and it is woken by a short high interval before the next start.
- **Deep sleep.** The converter is fully powered down, with a long settling delay on exit.

The sequencer derives every delay from the clock frequency given at elaboration:

- the nap wake-up time,
- the sleep wake-up time,
- the minimum spacing between starts, set by the maximum sample rate.

It holds a request that arrives too early until the conversion can legally begin. A second request that arrives while one is already pending sets a sticky overrun flag. A conversion whose end-of-conversion edge never comes is abandoned after a bounded number of cycles, and a sticky timeout flag is set.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is high and right after it, `convst_o`=1, `shdn_n_o`=0, `cs_n_o`=1, `rd_n_o`=1, `sample_o`=0, `sample_vld_o`=0, `overrun_o`=0 and `timeout_o`=0.
- R2: In full-power mode a conversion starts with a falling edge of `convst_o` while `shdn_n_o` stays 1. `convst_o` returns to 1 after PULSE_CYC+1 cycles, while the conversion is still running.
- R3: `adc_data_i` is captured in the first cycle in which `busy_i` is seen high after a start. `sample_vld_o` is high for exactly one cycle, in the following cycle.
- R4: With `bipolar_i`=1 as sampled at the start edge, `sample_o` bits 15:14 copy data bit 13 (two's complement). With `bipolar_i`=0 they are 0. A change of `bipolar_i` during a conversion has no effect on that sample.
- R5: Falling edges of `convst_o` are at least MIN_PER = ceil(CLK_KHZ*1000/MAX_SPS) cycles apart. A request made earlier is held and served, not dropped.
- R6: In auto-nap mode (`mode_i`=01), `shdn_n_o` falls together with `convst_o` at a start, and both stay 0 after the conversion. Before the next start both go to 1 for at least NAP = ceil(NAP_WAKE_NS*CLK_KHZ/10^6) cycles.
- R7: In deep-sleep mode (`mode_i`=10 or 11), `shdn_n_o`=0 and `cs_n_o`=1, and no conversion starts. After leaving sleep, no start occurs until at least SLEEP = SLEEP_WAKE_US*CLK_KHZ/1000 cycles after `cs_n_o` falls. A request made during sleep is served after that delay.
- R8: A request arriving while an earlier one is still pending sets `overrun_o`, which stays 1 until reset. No new conversion is added for it.
- R9: If `busy_i` does not rise within BUSY_TMO_CYC cycles of a start, `timeout_o` is set and stays 1 until reset. In that case no sample is delivered, `rd_n_o` returns to 1, and later requests convert normally.
- R10: `sample_o` holds the last captured value through nap and sleep, and only changes together with `sample_vld_o`.
- R11: `rd_n_o` is 0 from the start edge until the capture (or timeout) edge and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Single-cycle sample request |
| mode_i | input | 2 | Power mode: 00 full power, 01 auto-nap, 1x deep sleep |
| bipolar_i | input | 1 | Range of the next sample: 1 bipolar, 0 unipolar |
| busy_i | input | 1 | Converter end-of-conversion line, low while converting |
| adc_data_i | input | DW | Converter parallel data bus |
| convst_o | output | 1 | Conversion start, falling edge starts |
| shdn_n_o | output | 1 | Converter power, 0 shuts it down |
| cs_n_o | output | 1 | Converter chip select, active low |
| rd_n_o | output | 1 | Converter output-buffer enable, active low |
| sample_o | output | OW | Last captured sample, sign or zero extended |
| sample_vld_o | output | 1 | One-cycle pulse marking a new sample |
| overrun_o | output | 1 | Sticky: request while one was pending |
| timeout_o | output | 1 | Sticky: end-of-conversion never arrived |

## Verification
When the block is awake and idle, a request pulse held high for one cycle gives a falling edge on `convst_o` at the second rising edge that follows. The captured word and `sample_vld_o` appear one edge after the first edge at which `busy_i` is seen high. A timeout lands BUSY_TMO_CYC+1 edges after the start. The wake and spacing bounds are measured in cycles between port transitions: from the `cs_n_o` fall, from the `shdn_n_o` rise and from the previous `convst_o` fall, each up to the next start. The bench drives inputs and samples outputs on falling edges. A converter model releases `busy_i` a fixed number of cycles after each start, and each expected word is queued when the request is issued and popped only when `sample_vld_o` is seen, so every check keys on the observed event rather than on a guessed cycle.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_FULL  = 2'b00,
    MODE_NAP   = 2'b01,
    MODE_SLEEP = 2'b10,
    MODE_OFF2  = 2'b11
  } pwr_mode_e;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_WAKE = 3'd1,
    ST_IDLE = 3'd2,
    ST_CONV = 3'd3,
    ST_NAP  = 3'd4
  } seq_st_e;

  // timer slots
  localparam int T_WAKE = 0;
  localparam int T_PER  = 1;
  localparam int T_TMO  = 2;
  localparam int NTMR   = 3;

  function automatic longint ns_to_cyc(longint ns, longint khz);
    return (ns * khz + 999999) / 1000000;
  endfunction

  function automatic longint rate_to_cyc(longint khz, longint sps);
    return (khz * 1000 + sps - 1) / sps;
  endfunction

  function automatic longint lmax(longint a, longint b);
    return (a > b) ? a : b;
  endfunction

  function automatic int bits_for(longint n);
    int b;
    b = 1;
    while ((longint'(1) << b) <= n) b++;
    return b;
  endfunction

endpackage

// File: rtl/adc_seq_tmr.sv
`timescale 1ns/1ps
module adc_seq_tmr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/adc_seq_req.sv
`timescale 1ns/1ps
module adc_seq_req (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic take,
  output logic pend,
  output logic ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      pend <= (pend & ~take) | req;
      if (req && pend && !take) ovr <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_cap.sv
`timescale 1ns/1ps
module adc_seq_cap #(
  parameter int DW = 14,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          start,
  input  logic          bip_i,
  input  logic          busy_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_rise,
  output logic [OW-1:0] sample,
  output logic          vld
);
  logic          busy_q;
  logic          bip_q;
  logic [OW-1:0] ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b1;
      bip_q  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (start) bip_q <= bip_i;
    end
  end

  assign busy_rise = arm & ~busy_q & busy_i;

  generate
    if (OW > DW) begin : g_ext
      assign ext = {{(OW-DW){bip_q & data_i[DW-1]}}, data_i};
    end else begin : g_cut
      assign ext = data_i[OW-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sample <= '0;
      vld    <= 1'b0;
    end else begin
      vld <= busy_rise;
      if (busy_rise) sample <= ext;
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int            CW      = 8,
  parameter logic [CW-1:0] NAP_V   = '0,
  parameter logic [CW-1:0] SLEEP_V = '0,
  parameter logic [CW-1:0] PULSE_V = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  pwr_mode_e       mode,
  input  logic            pend,
  input  logic [NTMR-1:0] tz,
  input  logic            busy_rise,
  output logic            wake_ld,
  output logic [CW-1:0]   wake_val,
  output logic            start,
  output logic            arm,
  output logic            convst,
  output logic            shdn_n,
  output logic            cs_n,
  output logic            rd_n,
  output logic            tmo_err
);
  seq_st_e st;
  logic    nap_q;
  logic    sleep_req;
  logic    conv_end;

  assign sleep_req = mode[1];
  assign start     = (st == ST_IDLE) && !sleep_req && pend && tz[T_PER];
  assign arm       = (st == ST_CONV);
  assign conv_end  = busy_rise || tz[T_TMO];

  always_comb begin
    wake_ld  = 1'b0;
    wake_val = PULSE_V;
    case (st)
      ST_OFF: if (!sleep_req) begin
        wake_ld  = 1'b1;
        wake_val = SLEEP_V;
      end
      ST_NAP: if (!sleep_req && (mode == MODE_FULL || pend)) begin
        wake_ld  = 1'b1;
        wake_val = NAP_V;
      end
      ST_IDLE: if (start && mode != MODE_NAP) begin
        wake_ld  = 1'b1;
        wake_val = PULSE_V;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_OFF;
      convst  <= 1'b1;
      shdn_n  <= 1'b0;
      cs_n    <= 1'b1;
      rd_n    <= 1'b1;
      tmo_err <= 1'b0;
      nap_q   <= 1'b0;
    end else begin
      case (st)
        ST_OFF: if (!sleep_req) begin
          st     <= ST_WAKE;
          shdn_n <= 1'b1;
          cs_n   <= 1'b0;
        end
        ST_WAKE: begin
          if (sleep_req) begin
            st     <= ST_OFF;
            convst <= 1'b1;
            shdn_n <= 1'b0;
            cs_n   <= 1'b1;
          end else if (tz[T_WAKE]) begin
            st <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (sleep_req) begin
            st     <= ST_OFF;
            convst <= 1'b1;
            shdn_n <= 1'b0;
            cs_n   <= 1'b1;
          end else if (start) begin
            st     <= ST_CONV;
            convst <= 1'b0;
            rd_n   <= 1'b0;
            nap_q  <= (mode == MODE_NAP);
            if (mode == MODE_NAP) shdn_n <= 1'b0;
          end
        end
        ST_CONV: begin
          if (!nap_q && tz[T_WAKE]) convst <= 1'b1;
          if (conv_end) begin
            rd_n <= 1'b1;
            if (!busy_rise) tmo_err <= 1'b1;
            if (nap_q) begin
              st <= ST_NAP;
            end else begin
              st     <= ST_IDLE;
              convst <= 1'b1;
            end
          end
        end
        ST_NAP: begin
          if (sleep_req) begin
            st     <= ST_OFF;
            convst <= 1'b1;
            cs_n   <= 1'b1;
          end else if (mode == MODE_FULL || pend) begin
            st     <= ST_WAKE;
            convst <= 1'b1;
            shdn_n <= 1'b1;
          end
        end
        default: st <= ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DW            = 14,
  parameter int OW            = 16,
  parameter int CLK_KHZ       = 200000,
  parameter int NAP_WAKE_NS   = 500,
  parameter int SLEEP_WAKE_US = 10000,
  parameter int MAX_SPS       = 200000,
  parameter int BUSY_TMO_CYC  = 1024,
  parameter int PULSE_CYC     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic [1:0]    mode_i,
  input  logic          bipolar_i,
  input  logic          busy_i,
  input  logic [DW-1:0] adc_data_i,
  output logic          convst_o,
  output logic          shdn_n_o,
  output logic          cs_n_o,
  output logic          rd_n_o,
  output logic [OW-1:0] sample_o,
  output logic          sample_vld_o,
  output logic          overrun_o,
  output logic          timeout_o
);
  localparam longint NAP_CYC   = ns_to_cyc(longint'(NAP_WAKE_NS), longint'(CLK_KHZ));
  localparam longint SLEEP_CYC = ns_to_cyc(longint'(SLEEP_WAKE_US) * 1000, longint'(CLK_KHZ));
  localparam longint PER_CYC   = rate_to_cyc(longint'(CLK_KHZ), longint'(MAX_SPS));
  localparam int     CW        = bits_for(lmax(lmax(NAP_CYC, SLEEP_CYC),
                                   lmax(PER_CYC, lmax(longint'(BUSY_TMO_CYC), longint'(PULSE_CYC)))));

  localparam logic [CW-1:0] NAP_V   = CW'(NAP_CYC);
  localparam logic [CW-1:0] SLEEP_V = CW'(SLEEP_CYC);
  localparam logic [CW-1:0] PER_V   = CW'(PER_CYC - 1);
  localparam logic [CW-1:0] TMO_V   = CW'(BUSY_TMO_CYC);
  localparam logic [CW-1:0] PULSE_V = CW'(PULSE_CYC);

  logic            pend, start, arm, busy_rise;
  logic            wake_ld;
  logic [CW-1:0]   wake_val;
  logic [NTMR-1:0] tld;
  logic [NTMR-1:0] tz;
  logic [CW-1:0]   tval [NTMR];

  assign tld[T_WAKE]  = wake_ld;
  assign tld[T_PER]   = start;
  assign tld[T_TMO]   = start;
  assign tval[T_WAKE] = wake_val;
  assign tval[T_PER]  = PER_V;
  assign tval[T_TMO]  = TMO_V;

  generate
    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
      adc_seq_tmr #(.CW(CW)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (tld[i]),
        .val  (tval[i]),
        .zero (tz[i])
      );
    end
  endgenerate

  adc_seq_req u_req (
    .clk  (clk),
    .rst  (rst),
    .req  (req_i),
    .take (start),
    .pend (pend),
    .ovr  (overrun_o)
  );

  adc_seq_fsm #(
    .CW(CW), .NAP_V(NAP_V), .SLEEP_V(SLEEP_V), .PULSE_V(PULSE_V)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .mode      (pwr_mode_e'(mode_i)),
    .pend      (pend),
    .tz        (tz),
    .busy_rise (busy_rise),
    .wake_ld   (wake_ld),
    .wake_val  (wake_val),
    .start     (start),
    .arm       (arm),
    .convst    (convst_o),
    .shdn_n    (shdn_n_o),
    .cs_n      (cs_n_o),
    .rd_n      (rd_n_o),
    .tmo_err   (timeout_o)
  );

  adc_seq_cap #(.DW(DW), .OW(OW)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .start     (start),
    .bip_i     (bipolar_i),
    .busy_i    (busy_i),
    .data_i    (adc_data_i),
    .busy_rise (busy_rise),
    .sample    (sample_o),
    .vld       (sample_vld_o)
  );
endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int OW            = 16,
  parameter int CLK_KHZ       = 200000,
  parameter int NAP_WAKE_NS   = 500,
  parameter int SLEEP_WAKE_US = 10000,
  parameter int MAX_SPS       = 200000
) (
  input logic          clk,
  input logic          rst,
  input logic          convst_o,
  input logic          shdn_n_o,
  input logic          cs_n_o,
  input logic [OW-1:0] sample_o,
  input logic          sample_vld_o,
  input logic          overrun_o,
  input logic          timeout_o
);
  localparam longint NAP_L   = ns_to_cyc(longint'(NAP_WAKE_NS), longint'(CLK_KHZ));
  localparam longint SLEEP_L = ns_to_cyc(longint'(SLEEP_WAKE_US) * 1000, longint'(CLK_KHZ));
  localparam longint PER_L   = rate_to_cyc(longint'(CLK_KHZ), longint'(MAX_SPS));
  localparam logic [31:0] NAP_C   = 32'(NAP_L);
  localparam logic [31:0] SLEEP_C = 32'(SLEEP_L);
  localparam logic [31:0] PER_C   = 32'(PER_L);

  logic        cv_q, fall_now;
  logic [31:0] gap, hi, awake;

  assign fall_now = cv_q & ~convst_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cv_q  <= 1'b1;
      gap   <= '1;
      hi    <= '0;
      awake <= '0;
    end else begin
      cv_q  <= convst_o;
      gap   <= fall_now ? 32'd1 : ((gap == '1) ? gap : gap + 1);
      hi    <= !shdn_n_o ? '0 : ((hi == '1) ? hi : hi + 1);
      awake <= cs_n_o ? '0 : ((awake == '1) ? awake : awake + 1);
    end
  end

  // R5
  start_gap_chk: assert property (@(posedge clk) disable iff (rst)
    fall_now |-> gap >= PER_C);
  // R6
  nap_wake_chk: assert property (@(posedge clk) disable iff (rst)
    fall_now |-> hi >= NAP_C);
  // R7
  sleep_wake_chk: assert property (@(posedge clk) disable iff (rst)
    fall_now |-> awake >= SLEEP_C);
  // R3
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sample_vld_o |=> !sample_vld_o);
  // R10
  sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_vld_o |-> $stable(sample_o));
  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);
  // R9
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> timeout_o);
endmodule

bind adc_seq_ctrl adc_seq_chk #(
  .OW(OW), .CLK_KHZ(CLK_KHZ), .NAP_WAKE_NS(NAP_WAKE_NS),
  .SLEEP_WAKE_US(SLEEP_WAKE_US), .MAX_SPS(MAX_SPS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .convst_o     (convst_o),
  .shdn_n_o     (shdn_n_o),
  .cs_n_o       (cs_n_o),
  .sample_o     (sample_o),
  .sample_vld_o (sample_vld_o),
  .overrun_o    (overrun_o),
  .timeout_o    (timeout_o)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  localparam int NAP_C   = 20;
  localparam int SLEEP_C = 200;
  localparam int PER_C   = 100;
  localparam int TMO_C   = 64;
  localparam int CONV_C  = 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [1:0]  mode_i = 2'b10;
  logic        bipolar_i = 1'b0;
  logic        busy_i = 1'b1;
  logic [13:0] adc_data_i = '0;
  logic        convst_o, shdn_n_o, cs_n_o, rd_n_o, sample_vld_o, overrun_o, timeout_o;
  logic [15:0] sample_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit model_en = 1'b1;

  logic [15:0] exp_q[$];
  logic [13:0] dat_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_seq_ctrl #(
    .DW(14), .OW(16), .CLK_KHZ(200000), .NAP_WAKE_NS(100),
    .SLEEP_WAKE_US(1), .MAX_SPS(2000000), .BUSY_TMO_CYC(TMO_C), .PULSE_CYC(2)
  ) u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .mode_i(mode_i), .bipolar_i(bipolar_i),
    .busy_i(busy_i), .adc_data_i(adc_data_i), .convst_o(convst_o), .shdn_n_o(shdn_n_o),
    .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .sample_o(sample_o), .sample_vld_o(sample_vld_o),
    .overrun_o(overrun_o), .timeout_o(timeout_o)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt(input logic [13:0] d, input logic b);
    return b ? {{2{d[13]}}, d} : {2'b00, d};
  endfunction

  task automatic pulse_req();
    @(negedge clk) req_i = 1'b1;
    @(negedge clk) req_i = 1'b0;
  endtask

  task automatic do_conv(input logic [13:0] d, input logic b);
    bipolar_i = b;
    dat_q.push_back(d);
    exp_q.push_back(fmt(d, b));
    pulse_req();
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_fall();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!convst_o) break;
    end
  endtask

  // converter model
  int mcnt = 0;
  logic m_cv = 1'b1;
  always @(negedge clk) begin
    if (model_en && m_cv && !convst_o) begin
      busy_i = 1'b0;
      mcnt = CONV_C;
    end else if (mcnt > 0) begin
      mcnt = mcnt - 1;
      if (mcnt == 0) begin
        adc_data_i = (dat_q.size() > 0) ? dat_q.pop_front() : 14'h0;
        busy_i = 1'b1;
      end
    end
    m_cv = convst_o;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && sample_vld_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R3/R9 unexpected valid", {16'h0, sample_o}, 32'h0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(sample_o == e, "R3 R4 captured sample", {16'h0, sample_o}, {16'h0, e});
      end
    end
  end

  // start-timing monitor
  logic t_cv = 1'b1, t_cs = 1'b1, t_sh = 1'b0;
  int last_fall = -100000, cs_fall = 0, sh_rise = 0, n_start = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (t_cs && !cs_n_o) cs_fall = cyc;
      if (!t_sh && shdn_n_o) sh_rise = cyc;
      if (t_cv && !convst_o) begin
        n_start++;
        chk(cyc - last_fall >= PER_C, "R5 start spacing", cyc - last_fall, PER_C);
        chk(cyc - cs_fall >= SLEEP_C, "R7 sleep wake delay", cyc - cs_fall, SLEEP_C);
        if (mode_i == 2'b01) begin
          chk(!shdn_n_o, "R6 shutdown falls with start", shdn_n_o, 0);
          chk(cyc - sh_rise >= NAP_C, "R6 nap wake delay", cyc - sh_rise, NAP_C);
        end else begin
          chk(shdn_n_o, "R2 powered at start", shdn_n_o, 1);
        end
        last_fall = cyc;
      end
    end
    t_cv = convst_o;
    t_cs = cs_n_o;
    t_sh = shdn_n_o;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    wait_cyc(5);
    chk(convst_o == 1 && shdn_n_o == 0, "R1 reset lines", {convst_o, shdn_n_o}, 2'b10);
    chk(cs_n_o == 1 && rd_n_o == 1, "R1 reset strobes", {cs_n_o, rd_n_o}, 2'b11);
    rst = 1'b0;
    wait_cyc(1);
    chk(sample_o == 0 && sample_vld_o == 0, "R1 reset sample", sample_o, 0);
    chk(overrun_o == 0 && timeout_o == 0, "R1 reset flags", {overrun_o, timeout_o}, 0);

    // R7: request while sleeping is held
    do_conv(14'h1234, 1'b0);
    wait_cyc(50);
    chk(convst_o == 1 && shdn_n_o == 0 && cs_n_o == 1, "R7 stays asleep", {convst_o, shdn_n_o, cs_n_o}, 3'b101);
    mode_i = 2'b00;
    wait_cyc(SLEEP_C + 80);
    chk(n_start == 1, "R7 held request served", n_start, 1);
    chk(sample_o == 16'h1234, "R3 first sample", sample_o, 16'h1234);

    // R2 R11 mid-conversion probe, R4 range latched at start
    exp_q.push_back(fmt(14'h2001, 1'b1));
    dat_q.push_back(14'h2001);
    bipolar_i = 1'b1;
    pulse_req();
    wait_fall();
    bipolar_i = 1'b0;
    wait_cyc(5);
    chk(convst_o == 1, "R2 start pulse released", convst_o, 1);
    chk(rd_n_o == 0, "R11 read low during conversion", rd_n_o, 0);
    wait_cyc(PER_C + 20);
    chk(rd_n_o == 1, "R11 read released after capture", rd_n_o, 1);
    chk(sample_o == 16'hE001, "R4 range from start edge", sample_o, 16'hE001);

    do_conv(14'h3FFF, 1'b0); wait_cyc(PER_C + 20);
    do_conv(14'h3FFF, 1'b1); wait_cyc(PER_C + 20);
    do_conv(14'h2000, 1'b1); wait_cyc(PER_C + 20);
    do_conv(14'h1FFF, 1'b1); wait_cyc(PER_C + 20);
    do_conv(14'h0000, 1'b0); wait_cyc(PER_C + 20);

    // R5 early request held
    do_conv(14'h0AAA, 1'b0);
    wait_cyc(40);
    do_conv(14'h0555, 1'b0);
    wait_cyc(10);
    chk(convst_o == 1, "R5 early request not started yet", convst_o, 1);
    chk(overrun_o == 0, "R8 no overrun for single pending", overrun_o, 0);
    wait_cyc(2 * PER_C);
    chk(sample_o == 16'h0555, "R5 held request served", sample_o, 16'h0555);

    // R8 overrun
    do_conv(14'h0111, 1'b0);
    wait_cyc(40);
    do_conv(14'h0222, 1'b0);
    pulse_req();
    wait_cyc(1);
    chk(overrun_o == 1, "R8 overrun set", overrun_o, 1);
    wait_cyc(2 * PER_C);
    chk(overrun_o == 1, "R8 overrun sticky", overrun_o, 1);
    chk(exp_q.size() == 0 && sample_o == 16'h0222, "R8 no extra conversion", sample_o, 16'h0222);

    // R6 auto-nap
    mode_i = 2'b01;
    do_conv(14'h0F0F, 1'b1);
    wait_cyc(PER_C + 20);
    chk(convst_o == 0 && shdn_n_o == 0, "R6 napping after conversion", {convst_o, shdn_n_o}, 0);
    do_conv(14'h3210, 1'b1);
    wait_cyc(PER_C + 40);
    chk(sample_o == 16'hF210, "R6 nap conversion result", sample_o, 16'hF210);
    held = sample_o;
    wait_cyc(100);
    chk(sample_o == held && cs_n_o == 0, "R10 held during nap", sample_o, held);
    mode_i = 2'b10;
    wait_cyc(20);
    chk(shdn_n_o == 0 && cs_n_o == 1, "R7 sleep lines", {shdn_n_o, cs_n_o}, 2'b01);
    chk(sample_o == held, "R10 held during sleep", sample_o, held);

    // R9 timeout
    mode_i = 2'b00;
    wait_cyc(SLEEP_C + 40);
    model_en = 1'b0;
    pulse_req();
    wait_cyc(TMO_C + 20);
    chk(timeout_o == 1, "R9 timeout flagged", timeout_o, 1);
    chk(rd_n_o == 1, "R9 read released", rd_n_o, 1);
    chk(sample_o == held, "R9 no sample on timeout", sample_o, held);
    model_en = 1'b1;
    wait_cyc(PER_C);
    do_conv(14'h0777, 1'b0);
    wait_cyc(PER_C + 20);
    chk(sample_o == 16'h0777 && timeout_o == 1, "R9 recovers, flag sticky", sample_o, 16'h0777);
    chk(exp_q.size() == 0, "R3 all samples delivered", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule